// File: doc/BRIEF.md
# Double-Buffered Audio Serial Port (Slave)

This block is a two-channel audio serial port that follows an externally supplied bit clock and word-select (frame-sync) line. Received bits are assembled in a shift register, parked in a buffer register at the word boundary, and then copied into data registers that software reads. Transmit words take the same route in reverse. Software writes the data registers. At each frame start the port moves them into a buffer, and the buffer feeds the transmit shifter one word per channel slot. The serial lines are synchronized into the system clock domain, and all edge detection happens there.

The port runs in stereo (a left and a right word per frame) or mono (one word per frame, carried in the left slot). It raises a receive flag and a transmit flag each frame, in a stereo or mono variant. It also raises one shared error flag when software misses a read or a write before the next frame boundary. Every flag has its own mask bit. Software polls a small register interface with `reg_rd` and `reg_wr` strobes. A read of the flag register clears the flags. Data moves under software control with no valid/ready handshake, so back-pressure is not possible. A late read loses the old sample. A late write repeats the previous frame.

Top module: `i2s_slave_port`

## Requirements
- R1: In stereo mode (control register address 0, bit 0 = 0), word-select low marks the left slot and high marks the right slot. Each 16-bit word is taken MSB first on rising bit-clock edges, starting one bit after the word-select change. At the next frame start (word-select falling), the left and right words land in the receive data registers at addresses 3 and 4.
- R2: In mono mode (bit 0 = 1), only the left-slot word is received. It lands in address 3 when word-select rises. The right-slot word is ignored, and address 4 keeps its previous value.
- R3: A receive landing sets flag bit 0 (stereo) or flag bit 2 (mono) in the flag register (address 2), provided the matching mask bit is set in the mask register (address 1).
- R4: If data lands while the previous landing has not been consumed, the error flag (bit 4) is set when mask bit 4 is enabled, and the data registers take the new sample. A read of address 4 consumes a landing in stereo mode; a read of address 3 consumes it in mono mode.
- R5: At each frame start, the transmit data registers (left at address 5, right at address 6) are copied into the transmit buffer. The buffer is shifted out MSB first on `sd_out`, which changes only after a falling bit-clock edge. The first bit appears one bit after the word-select change. In mono mode the left word is sent in both slots.
- R6: Each frame start sets flag bit 1 (stereo) or flag bit 3 (mono) when masked in.
- R7: A frame start with no completed write since the previous frame start is an underrun. A write to address 6 completes the write in stereo mode; a write to address 5 completes it in mono mode. On an underrun, the error flag is set when mask bit 4 is enabled and the previous buffer contents are sent again.
- R8: In stereo mode, flag bits 2 and 3 never set; in mono mode, flag bits 0 and 1 never set. With mask bit 4 clear, the error flag never sets.
- R9: A read of the flag register returns the flags and clears them all. A flag raised in the same cycle as the read survives. `irq` is high exactly when some flag is set under the effective mask.
- R10: After reset the flags, the data registers, `sd_out` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word select / frame sync (low = left) |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | WORD_W | Register write data |
| reg_rd | input | 1 | Register read strobe (has side effects) |
| reg_rdata | output | WORD_W | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things. First, `sd_out` moves only after a detected falling bit-clock edge. Second, a receive landing or a frame start raises its mode's flag when masked in. Third, an underrun raises the error flag. Fourth, a flag read with no concurrent event leaves the flags empty, and flags that belong to the other mode or to a disabled error mask stay clear. Some behaviours show up only in whole-frame scenarios from the bench. These include the serial alignment of received and transmitted words, data overwritten after a skipped read, and the buffer repeated after a skipped or partial write. The bench drives randomized frames against a model of the intended frame timing.

// File: rtl/i2s_port_pkg.sv
`timescale 1ns/1ps
package i2s_port_pkg;
  localparam int FLAG_W = 5;
  localparam int FL_RX_ST = 0;
  localparam int FL_TX_ST = 1;
  localparam int FL_RX_MO = 2;
  localparam int FL_TX_MO = 3;
  localparam int FL_ERR   = 4;

  localparam logic [FLAG_W-1:0] STEREO_SET = 5'b10011;
  localparam logic [FLAG_W-1:0] MONO_SET   = 5'b11100;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_MASK  = 3'd1,
    A_FLAGS = 3'd2,
    A_RX_L  = 3'd3,
    A_RX_R  = 3'd4,
    A_TX_L  = 3'd5,
    A_TX_R  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/i2s_line_sync.sv
`timescale 1ns/1ps
module i2s_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_rise,
  output logic bit_fall,
  output logic frame_start,
  output logic half_start,
  output logic sd_bit
);
  localparam int LINES = 3;

  logic [LINES-1:0] chain [STAGES];
  logic             sck_prev;
  logic             ws_prev;
  logic             sck_s, ws_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= {sck_in, ws_in, sd_in};
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign sck_s  = chain[STAGES-1][2];
  assign ws_s   = chain[STAGES-1][1];
  assign sd_bit = chain[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      ws_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      if (bit_rise) ws_prev <= ws_s;
    end
  end

  assign bit_rise    = sck_s & ~sck_prev;
  assign bit_fall    = ~sck_s & sck_prev;
  assign frame_start = bit_rise & ~ws_s & ws_prev;
  assign half_start  = bit_rise & ws_s & ~ws_prev;
endmodule

// File: rtl/i2s_rx_path.sv
`timescale 1ns/1ps
module i2s_rx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              sd_bit,
  input  logic              frame_start,
  input  logic              half_start,
  input  logic              mono,
  output logic              land,
  output logic [WORD_W-1:0] buf_l,
  output logic [WORD_W-1:0] buf_r
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] hold_l;
  logic [WORD_W-1:0] word;

  assign word = {shreg[WORD_W-2:0], sd_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      hold_l <= '0;
      buf_l  <= '0;
      buf_r  <= '0;
      land   <= 1'b0;
    end else begin
      if (bit_rise) shreg <= word;
      if (half_start) begin
        if (mono) buf_l  <= word;
        else      hold_l <= word;
      end
      if (frame_start && !mono) begin
        buf_l <= hold_l;
        buf_r <= word;
      end
      land <= (half_start & mono) | (frame_start & ~mono);
    end
  end
endmodule

// File: rtl/i2s_tx_path.sv
`timescale 1ns/1ps
module i2s_tx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic              frame_start,
  input  logic              half_start,
  input  logic              mono,
  input  logic              take_new,
  input  logic [WORD_W-1:0] data_l,
  input  logic [WORD_W-1:0] data_r,
  output logic              sd_out
);
  logic [WORD_W-1:0] buf_l, buf_r, shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_l  <= '0;
      buf_r  <= '0;
      shreg  <= '0;
      sd_out <= 1'b0;
    end else begin
      if (frame_start) begin
        if (take_new) begin
          buf_l <= data_l;
          buf_r <= data_r;
        end
        shreg <= take_new ? data_l : buf_l;
      end else if (half_start) begin
        shreg <= mono ? buf_l : buf_r;
      end else if (bit_fall) begin
        sd_out <= shreg[WORD_W-1];
        shreg  <= {shreg[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2s_slave_port.sv
`timescale 1ns/1ps
module i2s_slave_port
  import i2s_port_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              sd_out,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PAD_W = WORD_W - FLAG_W;

  logic bit_rise, bit_fall, frame_start, half_start, sd_bit;
  logic rx_land;
  logic [WORD_W-1:0] rx_buf_l, rx_buf_r;

  logic              mono_q;
  logic [FLAG_W-1:0] mask_q, flags_q, mask_eff, set_v;
  logic [WORD_W-1:0] rx_l_q, rx_r_q, tx_l_q, tx_r_q;
  logic              rx_pend_q, tx_need_q;
  logic              rd_flags, rx_clr, tx_clr, overrun, underrun;

  i2s_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .bit_rise(bit_rise), .bit_fall(bit_fall), .frame_start(frame_start),
    .half_start(half_start), .sd_bit(sd_bit)
  );

  i2s_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .sd_bit(sd_bit),
    .frame_start(frame_start), .half_start(half_start), .mono(mono_q),
    .land(rx_land), .buf_l(rx_buf_l), .buf_r(rx_buf_r)
  );

  i2s_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .frame_start(frame_start),
    .half_start(half_start), .mono(mono_q), .take_new(~tx_need_q),
    .data_l(tx_l_q), .data_r(tx_r_q), .sd_out(sd_out)
  );

  assign rd_flags = reg_rd && (reg_addr == A_FLAGS);
  assign rx_clr   = reg_rd && (reg_addr == (mono_q ? A_RX_L : A_RX_R));
  assign tx_clr   = reg_wr && (reg_addr == (mono_q ? A_TX_L : A_TX_R));
  assign mask_eff = mask_q & (mono_q ? MONO_SET : STEREO_SET);
  assign overrun  = rx_land & rx_pend_q & ~rx_clr;
  assign underrun = frame_start & tx_need_q;

  always_comb begin
    set_v           = '0;
    set_v[FL_RX_ST] = rx_land & ~mono_q;
    set_v[FL_RX_MO] = rx_land & mono_q;
    set_v[FL_TX_ST] = frame_start & ~mono_q;
    set_v[FL_TX_MO] = frame_start & mono_q;
    set_v[FL_ERR]   = overrun | underrun;
    set_v           = set_v & mask_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mono_q    <= 1'b0;
      mask_q    <= '0;
      flags_q   <= '0;
      rx_l_q    <= '0;
      rx_r_q    <= '0;
      tx_l_q    <= '0;
      tx_r_q    <= '0;
      rx_pend_q <= 1'b0;
      tx_need_q <= 1'b0;
    end else begin
      flags_q <= (rd_flags ? '0 : flags_q) | set_v;
      if (rx_land) begin
        rx_l_q    <= rx_buf_l;
        rx_r_q    <= rx_buf_r;
        rx_pend_q <= 1'b1;
      end else if (rx_clr) begin
        rx_pend_q <= 1'b0;
      end
      if (frame_start)  tx_need_q <= 1'b1;
      else if (tx_clr)  tx_need_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: mono_q <= reg_wdata[0];
          A_MASK: mask_q <= reg_wdata[FLAG_W-1:0];
          A_TX_L: tx_l_q <= reg_wdata;
          A_TX_R: tx_r_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(WORD_W-1){1'b0}}, mono_q};
      A_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
      A_FLAGS: reg_rdata = {{PAD_W{1'b0}}, flags_q};
      A_RX_L:  reg_rdata = rx_l_q;
      A_RX_R:  reg_rdata = rx_r_q;
      A_TX_L:  reg_rdata = tx_l_q;
      A_TX_R:  reg_rdata = tx_r_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(flags_q & mask_eff);
endmodule

// File: rtl/i2s_slave_port_chk.sv
`timescale 1ns/1ps
module i2s_slave_port_chk
  import i2s_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mono,
  input logic [FLAG_W-1:0] mask_eff,
  input logic [FLAG_W-1:0] flags,
  input logic              irq,
  input logic              rd_flags,
  input logic              rx_land,
  input logic              frame_start,
  input logic              bit_fall,
  input logic              tx_need,
  input logic              sd_out
);
  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !rx_land && !frame_start) |=> (flags == '0));

  assert_mode_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mono && $past(!mono) && $past(flags[FL_RX_MO] == 1'b0) && $past(flags[FL_TX_MO] == 1'b0))
      |-> (flags[FL_RX_MO] == 1'b0 && flags[FL_TX_MO] == 1'b0));

  assert_err_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_eff[FL_ERR] && $past(!mask_eff[FL_ERR]) && $past(!flags[FL_ERR])) |-> !flags[FL_ERR]);

  assert_rx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_land && !mono && mask_eff[FL_RX_ST]) |=> flags[FL_RX_ST]);

  assert_tx_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !mono && mask_eff[FL_TX_ST]) |=> flags[FL_TX_ST]);

  assert_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && tx_need && mask_eff[FL_ERR]) |=> flags[FL_ERR]);

  assert_sd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_fall) |-> $stable(sd_out));
endmodule

bind i2s_slave_port i2s_slave_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mono(mono_q), .mask_eff(mask_eff), .flags(flags_q),
  .irq(irq), .rd_flags(rd_flags), .rx_land(rx_land), .frame_start(frame_start),
  .bit_fall(bit_fall), .tx_need(tx_need_q), .sd_out(sd_out)
);

// File: tb/test_i2s_slave_port.sv
`timescale 1ns/1ps
module test_i2s_slave_port;
  localparam int NF = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck_in = 1'b0, ws_in = 1'b1, sd_in = 1'b0;
  logic        sd_out;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  int cur_f = -1;
  logic [15:0] m_l [NF];
  logic [15:0] m_r [NF];
  logic [31:0] capt [NF];
  logic [31:0] exp_tx [NF];
  bit          do_rd [NF];
  int          wm [NF];

  always #4 clk = ~clk;

  i2s_slave_port i_i2s_slave_port (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .sd_out(sd_out), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sck_in = 1'b0; ws_in = 1'b1; sd_in = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic master_run();
    for (int f = 0; f < NF; f++) begin
      for (int j = 0; j < 32; j++) begin
        logic [31:0] fw;
        fw = {m_l[f], m_r[f]};
        ws_in = (j >= 16);
        if (j == 0) begin
          sd_in = (f == 0) ? 1'b0 : m_r[f-1][0];
          cur_f = f;
        end else begin
          sd_in = fw[32-j];
        end
        #64 sck_in = 1'b1;
        #1;
        if (j > 0) capt[f][32-j] = sd_out;
        else if (f > 0) capt[f-1][0] = sd_out;
        #63 sck_in = 1'b0;
      end
    end
    ws_in = 1'b1; sd_in = 1'b0;
  endtask

  task automatic cpu_run(input bit mono, input logic [4:0] mask,
                         input logic [15:0] txl0, input logic [15:0] txr0);
    logic [4:0]  meff, ef;
    logic [15:0] txl, txr, bl, br, d;
    bit          need, und, ovr;
    meff = mask & (mono ? 5'b11100 : 5'b10011);
    txl = txl0; txr = txr0; bl = '0; br = '0; need = 1'b0;
    for (int f = 0; f < NF; f++) begin
      wait (cur_f == f);
      repeat (40) @(negedge clk);
      und = need;
      if (!need) begin bl = txl; br = txr; end
      need = 1'b1;
      exp_tx[f] = mono ? {bl, bl} : {bl, br};
      if (mono) ovr = (f >= 2) && !do_rd[f-1];
      else      ovr = (f >= 1) && !do_rd[f-1];
      ef = '0;
      if (mono) begin ef[2] = (f >= 1); ef[3] = 1'b1; end
      else      begin ef[0] = 1'b1;     ef[1] = 1'b1; end
      ef[4] = ovr | und;
      ef = ef & meff;
      #1 chk("R9 irq level", {31'b0, irq}, {31'b0, |ef});
      rd(3'd2, d);
      chk("R3 R4 R6 R7 R8 flags", {16'b0, d}, {27'b0, ef});
      if (f == 3) begin
        rd(3'd2, d);
        chk("R9 flags cleared by read", {16'b0, d}, 32'd0);
        #1 chk("R9 irq after clear", {31'b0, irq}, 32'd0);
      end
      if (do_rd[f]) begin
        rd(3'd3, d);
        if (f >= 1) chk(mono ? "R2 mono rx word" : "R1 R4 rx left", {16'b0, d}, {16'b0, m_l[f-1]});
        if (!mono) begin
          rd(3'd4, d);
          if (f >= 1) chk("R1 R4 rx right", {16'b0, d}, {16'b0, m_r[f-1]});
        end
      end
      if (mono && f == 5) begin
        rd(3'd4, d);
        chk("R2 right slot ignored", {16'b0, d}, 32'd0);
      end
      case (wm[f])
        0: ;
        1: begin
          if (mono) begin txr = 16'($urandom); wr(3'd6, txr); end
          else      begin txl = 16'($urandom); wr(3'd5, txl); end
        end
        default: begin
          txl = 16'($urandom); wr(3'd5, txl);
          if (!mono) begin txr = 16'($urandom); wr(3'd6, txr); end
          need = 1'b0;
        end
      endcase
    end
  endtask

  task automatic run(input bit mono, input logic [4:0] mask);
    logic [15:0] t_l, t_r;
    for (int f = 0; f < NF; f++) begin
      m_l[f] = 16'($urandom); m_r[f] = 16'($urandom);
      do_rd[f] = ($urandom % 4) != 0;
      wm[f] = int'($urandom % 4);
      capt[f] = '0;
    end
    do_rd[4] = 1'b0; wm[4] = 0; wm[6] = 1; do_rd[7] = 1'b0; wm[8] = 2;
    cur_f = -1;
    t_l = 16'($urandom); t_r = 16'($urandom);
    wr(3'd0, {15'b0, mono});
    wr(3'd1, {11'b0, mask});
    wr(3'd5, t_l);
    wr(3'd6, t_r);
    fork
      master_run();
      cpu_run(mono, mask, t_l, t_r);
    join
    for (int f = 0; f < NF - 1; f++)
      chk(mono ? "R5 R7 mono tx frame" : "R5 R7 stereo tx frame", capt[f], exp_tx[f]);
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd8675309));
    do_reset();
    chk("R10 irq after reset", {31'b0, irq}, 32'd0);
    chk("R10 sd_out after reset", {31'b0, sd_out}, 32'd0);
    rd(3'd2, d); chk("R10 flags after reset", {16'b0, d}, 32'd0);
    rd(3'd3, d); chk("R10 rx left after reset", {16'b0, d}, 32'd0);
    rd(3'd4, d); chk("R10 rx right after reset", {16'b0, d}, 32'd0);
    run(1'b0, 5'b11111);
    do_reset();
    run(1'b1, 5'b01111);
    do_reset();
    run(1'b1, 5'b11111);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule